// File: doc/BRIEF.md
# Parallel Port with Serial Output Takeover

This block is a small parallel I/O port for a CPU. Each pin has three control bits: a data bit, a direction bit and a pulldown-inhibit bit. The CPU reaches them over a simple synchronous read/write bus. The block drives the pad's output value, output enable and pulldown enable, and it reads back the level at the pad.

One pin, chosen by a parameter, can be handed to a serial peripheral. While the peripheral's enable input is high, that pin's output buffer is switched on and carries the peripheral's serial data, whatever the CPU registers hold. The pulldown on that pin is switched off. The CPU can still read and write every register, and doing so does not move the pin. When the enable drops, the pin goes back to the values held in its registers. A global pulldown-disable input turns the pulldowns off on every pin.

The registers use three fixed offsets. Data is at 0x01, direction is at 0x05, and pulldown-inhibit is at 0x11. The pulldown-inhibit register can be written but not read back.

Top module: `gpio_sovr_port`

## Requirements
- R1: After a synchronous reset, the data, direction and pulldown-inhibit bits are all 0. Every pin then has pad_oe=0, and pad_pd=1 while pd_global_off is 0.
- R2: A write with bus_wr high updates a register on that clock edge. Offset 0x01 writes data, offset 0x05 writes direction and offset 0x11 writes pulldown-inhibit. Writes to any other offset change no register.
- R3: A read with bus_rd high loads bus_rdata on that clock edge, and bus_rdata holds that value until the next read. Offset 0x05 returns the direction bits. Offset 0x11 and every unmapped offset return 0.
- R4: A read at offset 0x01 returns, for each bit, the pad_in level when its direction bit is 0 and the data bit when its direction bit is 1.
- R5: For a pin the serial peripheral does not own, pad_oe equals its direction bit and pad_out equals its data bit.
- R6: While ser_en is 1, pin SER_BIT has pad_oe=1 and pad_out=ser_dout, whatever its direction and data bits hold.
- R7: While ser_en is 1, pad_pd of pin SER_BIT is 0.
- R8: CPU writes made while ser_en is 1 do not change pin SER_BIT. After ser_en returns to 0, that pin follows the register values as they stand, including values written during the takeover.
- R9: The pad_pd of a pin is 1 only when that pin is not owned by the serial peripheral, its direction bit is 0, its pulldown-inhibit bit is 0 and pd_global_off is 0.
- R10: While pd_global_off is 1, every bit of pad_pd is 0.
- R11: ser_en and ser_dout have no effect on any pin other than SER_BIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| ser_en | input | 1 | Serial peripheral takes over pin SER_BIT |
| ser_dout | input | 1 | Serial data driven onto pin SER_BIT |
| pd_global_off | input | 1 | Turns off every pulldown |
| pad_in | input | WIDTH | Levels seen at the pads |
| pad_out | output | WIDTH | Output values to the pads |
| pad_oe | output | WIDTH | Output buffer enables |
| pad_pd | output | WIDTH | Pulldown enables |

## Verification
The assertions check the takeover on every cycle: the serial pin driving ser_dout with its pulldown off, the global pulldown disable, and register loading, holding and the readback of 0 from the write-only offset. The pulldown truth table, the direction-dependent data read, the return of the pin after the takeover ends and the isolation of the other pins depend on combinations of register contents. Only the bench's sweep over every control combination, and its takeover scenario, show those.

// File: rtl/gpio_sovr_pkg.sv
package gpio_sovr_pkg;
  localparam int ADDR_W = 5;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t OFS_DATA  = 5'h01;
  localparam addr_t OFS_DIR   = 5'h05;
  localparam addr_t OFS_PDINH = 5'h11;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_PDINH
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(addr_t a);
    reg_sel_e s;
    if (a == OFS_DATA)       s = SEL_DATA;
    else if (a == OFS_DIR)   s = SEL_DIR;
    else if (a == OFS_PDINH) s = SEL_PDINH;
    else                     s = SEL_NONE;
    return s;
  endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_sovr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  addr_t            addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pin_view,
  output logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] inh_q
);
  reg_sel_e sel;
  assign sel = decode_ofs(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      inh_q  <= '0;
      rdata  <= '0;
    end else begin
      if (wr_en) begin
        unique case (sel)
          SEL_DATA:  data_q <= wdata;
          SEL_DIR:   dir_q  <= wdata;
          SEL_PDINH: inh_q  <= wdata;
          default:   ;
        endcase
      end
      if (rd_en) begin
        unique case (sel)
          SEL_DATA: rdata <= pin_view;
          SEL_DIR:  rdata <= dir_q;
          default:  rdata <= '0;
        endcase
      end
    end
  end

  // R2: a data write lands on the strobe edge
  assert_wr_data_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DATA) |=> data_q == $past(wdata));

  // R2: without a write the direction bits hold
  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> $stable(dir_q));

  // R3: the write-only offset reads back as zero
  assert_rd_pdinh_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_PDINH) |=> rdata == '0);

  // R3: read data holds between reads
  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!rd_en) |=> $stable(rdata));
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice (
  input  logic own_en,
  input  logic own_dout,
  input  logic pd_off,
  input  logic data_b,
  input  logic dir_b,
  input  logic inh_b,
  input  logic pad_in_b,
  output logic pad_out_b,
  output logic pad_oe_b,
  output logic pad_pd_b,
  output logic view_b
);
  always_comb begin
    if (own_en) begin
      pad_oe_b  = 1'b1;
      pad_out_b = own_dout;
    end else begin
      pad_oe_b  = dir_b;
      pad_out_b = data_b;
    end
    pad_pd_b = ~own_en & ~dir_b & ~inh_b & ~pd_off;
    view_b   = dir_b ? data_b : pad_in_b;
  end
endmodule

// File: rtl/gpio_sovr_port.sv
module gpio_sovr_port #(
  parameter int WIDTH   = 8,
  parameter int SER_BIT = 5,
  parameter int ADDR_W  = gpio_sovr_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              ser_en,
  input  logic              ser_dout,
  input  logic              pd_global_off,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pd
);
  localparam int OWNED = (SER_BIT < WIDTH) ? SER_BIT : WIDTH - 1;

  logic [WIDTH-1:0] data_q, dir_q, inh_q, pin_view;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr),
    .rd_en   (bus_rd),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .pin_view(pin_view),
    .rdata   (bus_rdata),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .inh_q   (inh_q)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic own_en_i, own_dout_i;
    if (i == OWNED) begin : g_ser
      assign own_en_i   = ser_en;
      assign own_dout_i = ser_dout;
    end else begin : g_plain
      assign own_en_i   = 1'b0;
      assign own_dout_i = 1'b0;
    end

    gpio_pin_slice u_slice (
      .own_en   (own_en_i),
      .own_dout (own_dout_i),
      .pd_off   (pd_global_off),
      .data_b   (data_q[i]),
      .dir_b    (dir_q[i]),
      .inh_b    (inh_q[i]),
      .pad_in_b (pad_in[i]),
      .pad_out_b(pad_out[i]),
      .pad_oe_b (pad_oe[i]),
      .pad_pd_b (pad_pd[i]),
      .view_b   (pin_view[i])
    );
  end

  // R6: the serial peripheral drives its pin
  assert_ser_drive_R6: assert property (@(posedge clk) disable iff (rst)
    ser_en |-> (pad_oe[OWNED] && pad_out[OWNED] == ser_dout));

  // R7: no pulldown on the owned pin
  assert_ser_nopd_R7: assert property (@(posedge clk) disable iff (rst)
    ser_en |-> !pad_pd[OWNED]);

  // R10: global pulldown disable
  assert_gdis_nopd_R10: assert property (@(posedge clk) disable iff (rst)
    pd_global_off |-> (pad_pd == '0));

  // R1: the cycle after reset every pin is an input
  assert_reset_input_R1: assert property (@(posedge clk)
    $fell(rst) |-> (pad_oe == '0));
endmodule

// File: tb/gpio_sovr_port_test.sv
module gpio_sovr_port_test;
  localparam int W = 8;
  localparam int SB = 5;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic ser_en = 1'b0, ser_dout = 1'b0, pd_global_off = 1'b0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe, pad_pd;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_sovr_port #(.WIDTH(W), .SER_BIT(SB)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_en(ser_en), .ser_dout(ser_dout), .pd_global_off(pd_global_off),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd(pad_pd)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [W-1:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [W-1:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [W-1:0] rv;
    logic [W-1:0] exp_oe, exp_out, exp_pd, exp_rd;
    pad_in = 8'h5A;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 oe after reset", pad_oe, '0);
    check("R1 pd after reset", pad_pd, '1);
    reg_rd(5'h05, rv); check("R1 dir after reset", rv, '0);
    // R4 input read returns pad level
    reg_rd(5'h01, rv); check("R4 read pad level", rv, 8'h5A);
    // R3 write-only and unmapped offsets read 0
    reg_wr(5'h11, 8'hFF);
    reg_rd(5'h11, rv); check("R3 pdinh reads zero", rv, '0);
    check("R9 pdinh set kills pd", pad_pd, '0);
    reg_rd(5'h03, rv); check("R3 unmapped reads zero", rv, '0);
    // R3 rdata holds between reads
    repeat (3) @(negedge clk);
    check("R3 rdata holds", bus_rdata, '0);
    // R2 unmapped writes are ignored
    reg_wr(5'h11, 8'h00);
    reg_wr(5'h05, 8'h3C);
    reg_wr(5'h00, 8'hFF);
    reg_wr(5'h02, 8'hFF);
    reg_wr(5'h15, 8'hFF);
    reg_rd(5'h05, rv); check("R2 dir after stray writes", rv, 8'h3C);
    check("R5 oe follows dir", pad_oe, 8'h3C);
    reg_wr(5'h01, 8'hA5);
    check("R5 out follows data", pad_out, 8'hA5);
    reg_rd(5'h01, rv); check("R4 mixed read", rv, (8'hA5 & 8'h3C) | (8'h5A & ~8'h3C));

    // Exhaustive sweep over the per-pin control combinations (R4 R5 R6 R7 R9 R10 R11)
    for (int c = 0; c < 128; c++) begin
      logic s, d, q, h, g, o, p;
      {s, d, q, h, g, o, p} = c[6:0];
      reg_wr(5'h01, {W{q}});
      reg_wr(5'h05, {W{d}});
      reg_wr(5'h11, {W{h}});
      @(negedge clk);
      ser_en = s; pd_global_off = g; ser_dout = o; pad_in = {W{p}};
      @(negedge clk);
      for (int i = 0; i < W; i++) begin
        logic own;
        own = s && (i == SB);
        exp_oe[i]  = own ? 1'b1 : d;
        exp_out[i] = own ? o : q;
        exp_pd[i]  = !own && !d && !h && !g;
        exp_rd[i]  = d ? q : p;
      end
      check("R6 R11 oe sweep", pad_oe, exp_oe);
      check("R6 R11 out sweep", pad_out, exp_out);
      check("R7 R9 R10 pd sweep", pad_pd, exp_pd);
      reg_rd(5'h01, rv); check("R4 data read sweep", rv, exp_rd);
    end

    // R8 writes during takeover leave the pin alone, then take effect
    ser_en = 1'b0; pd_global_off = 1'b0; pad_in = 8'h00;
    reg_wr(5'h05, 8'h00);
    reg_wr(5'h01, 8'h00);
    reg_wr(5'h11, 8'h00);
    @(negedge clk);
    ser_en = 1'b1; ser_dout = 1'b1;
    reg_wr(5'h05, 8'hFF);
    reg_wr(5'h01, 8'h00);
    check("R8 owned pin out during writes", {7'b0, pad_out[SB]}, 8'h01);
    ser_dout = 1'b0;
    reg_wr(5'h01, 8'hFF);
    check("R8 owned pin follows serial", {7'b0, pad_out[SB]}, 8'h00);
    reg_rd(5'h01, rv); check("R8 cpu data readable", rv, 8'hFF);
    reg_wr(5'h05, 8'h00);
    check("R8 owned oe kept", {7'b0, pad_oe[SB]}, 8'h01);
    check("R8 owned pd off", {7'b0, pad_pd[SB]}, 8'h00);
    reg_wr(5'h05, 8'hFF);
    @(negedge clk);
    ser_en = 1'b0;
    @(negedge clk);
    check("R8 release oe from dir", pad_oe, 8'hFF);
    check("R8 release out from data", pad_out, 8'hFF);

    // R1 reset again clears registers
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 oe after second reset", pad_oe, '0);
    check("R1 out after second reset", pad_out, '0);
    check("R1 pd after second reset", pad_pd, '1);

    done = 1'b1;
    summary();
  end
endmodule